// File: doc/BRIEF.md
# 5-bit Symbol Receive Decoder and Framer

This block sits after symbol alignment in a 100 Mb/s style receive path. Each cycle in which `sym_valid` is high, it takes one aligned 5-bit code group. It then drives a nibble-wide receive interface made of a data nibble, carrier sense and data valid. A frame opens on the two-symbol start delimiter J (`11000`) followed by K (`10001`). It closes on the end delimiter T (`01101`) followed by R (`00111`). Inside a frame, data symbols are turned back into nibbles.

The outputs are registered. They change only on a clock edge where `sym_valid` is high. Inside a frame, each nibble leaves one symbol slot after its symbol arrives. This one-slot delay lets the J and K slots come out as two `0101` preamble nibbles, but only after K has confirmed the start. The frame on the receive side therefore has the same structure as the transmitted one. Carrier sense and data valid are always equal. The bench samples on the falling edge of the clock.

Top module: `sym5b_rx_framer`

## Requirements
- R1: After reset, and at all times outside a frame, `crs` and `rx_dv` are 0 and `rxd` is `0000`.
- R2: On the strobe that accepts K directly after J, `crs` and `rx_dv` go to 1 with `rxd`=`0101`. The next strobe shows `0101` again.
- R3: Inside a frame, the data codes map to nibbles as follows. 11110→0, 01001→1, 10100→2, 10101→3, 01010→4, 01011→5, 01110→6, 01111→7, 10010→8, 10011→9, 10110→A, 10111→B, 11010→C, 11011→D, 11100→E, 11101→F.
- R4: Each in-frame nibble appears on `rxd` at the strobe after the strobe that accepted its symbol.
- R5: Inside a frame, any code other than the sixteen data codes and I, T, R, J, K decodes to `0000`, and the frame continues. This includes H (`00100`).
- R6: Inside a frame, J and K decode to `0101`, and the frame continues.
- R7: On the strobe that accepts T, the last data nibble is shown with `rx_dv`=1. On the next strobe, if that symbol is R, the outputs return to the quiet state of R1.
- R8: If J is followed by anything other than K, `rx_dv` stays 0 (false carrier). A second J restarts the search, so J J K still opens a frame.
- R9: If I (`11111`) arrives inside a frame before a T, the outputs go quiet on the strobe that accepts it.
- R10: After a T, the next symbol closes the frame even if it is not R. The outputs go quiet on that strobe.
- R11: In a cycle where `sym_valid` is 0, no output changes on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_valid | input | 1 | High when `sym_in` holds a new aligned code group |
| sym_in | input | 5 | Aligned 5-bit code group |
| rxd | output | 4 | Decoded receive nibble, `0000` when not valid |
| crs | output | 1 | Carrier sense |
| rx_dv | output | 1 | Receive data valid |

## Verification
A framer state that is out of step shows up within one or two strobes. It shows as `rx_dv` rising without a J-K pair, staying high after T-R or I, or as the preamble count being wrong. A decode error or a fault in the holding register shows on the very next strobe as a wrong nibble or a nibble shifted by one slot. The bench therefore checks the outputs after every single strobe, and also checks them after idle gaps when the strobe is low.

// File: rtl/sym5b_rx_framer.sv
module sym5b_rx_framer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sym_valid,
  input  logic [4:0] sym_in,
  output logic [3:0] rxd,
  output logic       crs,
  output logic       rx_dv
);
  localparam logic [4:0] C_I = 5'b11111;
  localparam logic [4:0] C_J = 5'b11000;
  localparam logic [4:0] C_K = 5'b10001;
  localparam logic [4:0] C_T = 5'b01101;

  typedef enum logic [1:0] {S_IDLE, S_J, S_DATA, S_T} st_t;
  st_t        st;
  logic [3:0] held;
  logic [3:0] rxd_q;
  logic       dv_q;

  function automatic logic [3:0] dec(input logic [4:0] c);
    case (c)
      5'b11110: dec = 4'h0;
      5'b01001: dec = 4'h1;
      5'b10100: dec = 4'h2;
      5'b10101: dec = 4'h3;
      5'b01010: dec = 4'h4;
      5'b01011: dec = 4'h5;
      5'b01110: dec = 4'h6;
      5'b01111: dec = 4'h7;
      5'b10010: dec = 4'h8;
      5'b10011: dec = 4'h9;
      5'b10110: dec = 4'hA;
      5'b10111: dec = 4'hB;
      5'b11010: dec = 4'hC;
      5'b11011: dec = 4'hD;
      5'b11100: dec = 4'hE;
      5'b11101: dec = 4'hF;
      C_J, C_K: dec = 4'h5;
      default:  dec = 4'h0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      held  <= 4'h0;
      rxd_q <= 4'h0;
      dv_q  <= 1'b0;
    end else if (sym_valid) begin
      case (st)
        S_IDLE: begin
          rxd_q <= 4'h0;
          dv_q  <= 1'b0;
          if (sym_in == C_J) st <= S_J;
        end
        S_J: begin
          if (sym_in == C_K) begin
            st    <= S_DATA;
            held  <= 4'h5;
            rxd_q <= 4'h5;
            dv_q  <= 1'b1;
          end else begin
            st    <= (sym_in == C_J) ? S_J : S_IDLE;
            rxd_q <= 4'h0;
            dv_q  <= 1'b0;
          end
        end
        S_DATA: begin
          if (sym_in == C_I) begin
            st    <= S_IDLE;
            rxd_q <= 4'h0;
            dv_q  <= 1'b0;
          end else begin
            rxd_q <= held;
            dv_q  <= 1'b1;
            if (sym_in == C_T) st <= S_T;
            else               held <= dec(sym_in);
          end
        end
        default: begin
          st    <= S_IDLE;
          rxd_q <= 4'h0;
          dv_q  <= 1'b0;
        end
      endcase
    end
  end

  assign rxd   = rxd_q;
  assign rx_dv = dv_q;
  assign crs   = dv_q;

  p_quiet_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_dv |-> rxd == 4'h0);
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid && st == S_J && sym_in == C_K |=> rx_dv && rxd == 4'h5);
  p_false_carrier_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid && st == S_J && sym_in != C_K |=> !rx_dv);
  p_idle_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid && st == S_DATA && sym_in == C_I |=> !rx_dv && !crs);
  p_close_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid && st == S_T |=> !rx_dv);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid |=> $stable(rxd) && $stable(rx_dv));
endmodule

// File: tb/sym5b_rx_framer_test.sv
module sym5b_rx_framer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sym_valid = 1'b0;
  logic [4:0] sym_in = 5'b0;
  logic [3:0] rxd;
  logic       crs, rx_dv;
  int total = 0;
  int bad = 0;

  localparam logic [4:0] J = 5'b11000, K = 5'b10001, T = 5'b01101,
                         R = 5'b00111, I = 5'b11111, H = 5'b00100;

  sym5b_rx_framer uut (.clk(clk), .rst_n(rst_n), .sym_valid(sym_valid),
    .sym_in(sym_in), .rxd(rxd), .crs(crs), .rx_dv(rx_dv));

  always #10 clk = ~clk;

  function automatic logic [4:0] enc(input logic [3:0] n);
    logic [4:0] tbl [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                             5'b01010, 5'b01011, 5'b01110, 5'b01111,
                             5'b10010, 5'b10011, 5'b10110, 5'b10111,
                             5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return tbl[n];
  endfunction

  task automatic chk(input bit dv, input logic [3:0] d, input string tag);
    total++;
    if (rx_dv !== dv || crs !== dv || rxd !== d) begin
      bad++;
      $display("FAIL %s: dv=%b crs=%b rxd=%h expected dv=%b crs=%b rxd=%h",
               tag, rx_dv, crs, rxd, dv, dv, d);
    end
  endtask

  task automatic put(input logic [4:0] s, input bit dv, input logic [3:0] d,
                     input string tag);
    @(negedge clk);
    sym_in = s; sym_valid = 1'b1;
    @(negedge clk);
    sym_valid = 1'b0;
    chk(dv, d, tag);
  endtask

  task automatic t_reset;
    chk(1'b0, 4'h0, "R1 reset");
    put(I, 0, 0, "R1 idle outside");
    put(5'h05, 0, 0, "R1 data outside");
    put(K, 0, 0, "R1 lone K");
  endtask

  task automatic t_all_data;
    put(J, 0, 0, "R8 J pending");
    put(K, 1, 4'h5, "R2 first preamble");
    put(enc(4'h0), 1, 4'h5, "R2 second preamble");
    for (int n = 1; n < 16; n++)
      put(enc(n[3:0]), 1, 4'(n - 1), "R3 R4 decode");
    put(T, 1, 4'hF, "R7 last nibble on T");
    put(R, 0, 0, "R7 end on R");
    put(enc(4'h9), 0, 0, "R1 after frame");
  endtask

  task automatic t_odd_codes;
    put(J, 0, 0, "R8 J pending");
    put(K, 1, 5, "R2 preamble");
    put(H, 1, 5, "R2 preamble 2");
    put(5'b00000, 1, 0, "R5 H decodes 0");
    put(J, 1, 0, "R5 unused decodes 0");
    put(K, 1, 5, "R6 J in frame");
    put(enc(4'hA), 1, 5, "R6 K in frame");
    put(T, 1, 4'hA, "R7 last nibble");
    put(R, 0, 0, "R7 closed");
  endtask

  task automatic t_false_carrier;
    put(J, 0, 0, "R8 J");
    put(enc(4'h3), 0, 0, "R8 J then data");
    put(K, 0, 0, "R8 K after abort");
    put(J, 0, 0, "R8 J again");
    put(J, 0, 0, "R8 J J");
    put(K, 1, 5, "R8 J J K opens");
    put(I, 0, 0, "R9 idle right after K");
  endtask

  task automatic t_idle_abort;
    put(J, 0, 0, "R9 J");
    put(K, 1, 5, "R9 preamble");
    put(enc(4'h7), 1, 5, "R9 preamble 2");
    put(enc(4'hC), 1, 7, "R9 data");
    put(I, 0, 0, "R9 idle abort");
    put(enc(4'h1), 0, 0, "R9 stays idle");
  endtask

  task automatic t_bad_close;
    put(J, 0, 0, "R10 J");
    put(K, 1, 5, "R10 preamble");
    put(enc(4'h2), 1, 5, "R10 preamble 2");
    put(T, 1, 2, "R10 T");
    put(enc(4'h4), 0, 0, "R10 non-R closes");
    put(enc(4'h6), 0, 0, "R10 stays idle");
  endtask

  task automatic t_gaps;
    put(J, 0, 0, "R11 J");
    put(K, 1, 5, "R11 preamble");
    @(negedge clk); sym_in = enc(4'hB);
    repeat (3) @(negedge clk);
    chk(1, 5, "R11 hold with strobe low");
    put(enc(4'hB), 1, 5, "R11 preamble 2");
    sym_in = T;
    repeat (2) @(negedge clk);
    chk(1, 5, "R11 hold again");
    put(I, 0, 0, "R11 close");
    sym_in = J;
    repeat (2) @(negedge clk);
    chk(0, 0, "R11 quiet hold");
  endtask

  initial begin
    #(20 * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_all_data;
    t_odd_codes;
    t_false_carrier;
    t_idle_abort;
    t_bad_close;
    t_gaps;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule